// File: doc/BRIEF.md
# Serial-Access Memory Self-Test Engine

This block tests a synchronous single-port memory through one serial bit. It does not build a full data word for every write. Instead it writes the word it has just read back, shifted down by one bit position, with a single fill bit entering at the most significant end. Starting from a background word that is the inverse of the fill bit, each word is filled one bit position at a time until every bit equals the fill bit. The bit that falls off the least significant end of each read is the serial output. That bit is compared against the value it should have.

A run starts with a start pulse, and the fill bit is taken from `ser_in` at that moment. The engine visits every address of the memory in ascending order. It drives the address, the enables and the write data directly, and it expects read data one cycle after a read enable. The cost of this scheme is test time: about two cycles per bit of word width for each address. In exchange, only one serial line and a one-bit comparator are needed. Any mismatch latches a fail flag, which holds until the next run. When the last address is finished, `done` rises and stays high.

Top module: `serial_mem_bist`

## Requirements
- R1: Terms used below: s is the fill bit and W is the word width. At each address the engine first writes the background word, which has every bit equal to ~s. It then performs W steps, each a read followed by a write. The write data is the word just read, shifted right by one position, with s entering bit W-1. On a fault-free memory, write number k at an address (k=0 is the background write) therefore has its top k bits equal to s and its other bits equal to ~s.
- R2: A read enable and a write enable are never active in the same cycle. Read data is taken one cycle after the read enable.
- R3: The first W reads at an address are each expected to show ~s on the serial output. The final read, made after the W-th shift-write, is expected to show s.
- R4: Addresses are visited in ascending order from 0 to 2^ADDR_W-1. Each address receives exactly W+1 writes and W+1 reads.
- R5: `busy` is high for exactly 2^ADDR_W*(2W+3) cycles per run. After that, `done` is high and `busy` is low, and no memory access is made until the next start.
- R6: `fail` is cleared when a start is accepted. It becomes set on any serial-output mismatch and then stays set for the rest of the run and after it. A single stuck-at bit anywhere in the memory makes `fail` end high.
- R7: While `busy` is high, `start` and `ser_in` have no effect. The fill bit is sampled only when a start is accepted.
- R8: After reset, `busy`, `done`, `fail`, `mem_we` and `mem_re` are all low.
- R9: `ser_out` equals bit 0 of `mem_rdata` in every cycle.
- R10: After a fault-free run, every word of the memory holds all bits equal to s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| start | input | 1 | Run request, accepted while idle |
| ser_in | input | 1 | Fill bit, sampled when a start is accepted |
| ser_out | output | 1 | Serial output: the bit shifted out of each read word |
| mem_addr | output | ADDR_W | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after mem_re |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; held until the next start |
| fail | output | 1 | Sticky mismatch flag |

## Verification
The hardest behaviour to reach is a fault whose effect is delayed. A stuck-at bit in the middle of a word is not visible when it is first written. It only appears at the serial output after the shift chain has carried it down to bit 0, or after it has corrupted the fill bit that the final read depends on. The bench memory model therefore forces randomly chosen stuck-at bits at random addresses, with random fill polarity, so that detection is exercised at many different delays. Directed runs cover faults at the top bit and at the bottom bit, restarts with the fill bit changed, and start pulses made in the middle of a run.

// File: rtl/sbist_pkg.sv
package sbist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_INIT = 3'd1,
    ST_RD   = 3'd2,
    ST_WR   = 3'd3,
    ST_CHK  = 3'd4
  } sb_state_e;
endpackage

// File: rtl/sbist_seq.sv
module sbist_seq
  import sbist_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output sb_state_e         st_o,
  output logic              accept_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int STEP_W = $clog2(DATA_W + 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(DATA_W);
  localparam logic [ADDR_W-1:0] ADDR_LAST = {ADDR_W{1'b1}};

  sb_state_e         st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              done_q, done_d;
  logic              upd;

  assign accept_o = (st_q == ST_IDLE) && start_i;
  assign upd      = (st_q != ST_IDLE) || start_i;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    step_d = step_q;
    done_d = done_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_INIT;
          addr_d = '0;
          step_d = '0;
          done_d = 1'b0;
        end
      end
      ST_INIT: st_d = ST_RD;
      ST_RD:   st_d = (step_q == STEP_LAST) ? ST_CHK : ST_WR;
      ST_WR: begin
        step_d = step_q + STEP_W'(1);
        st_d   = ST_RD;
      end
      ST_CHK: begin
        step_d = '0;
        if (addr_q == ADDR_LAST) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          addr_d = addr_q + ADDR_W'(1);
          st_d   = ST_INIT;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      step_q <= '0;
      done_q <= 1'b0;
    end else if (upd) begin
      st_q   <= st_d;
      addr_q <= addr_d;
      step_q <= step_d;
      done_q <= done_d;
    end
  end

  assign st_o   = st_q;
  assign addr_o = addr_q;
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;

  a_r1_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= STEP_LAST);
  a_r4_addr_ascend: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CHK && addr_q != ADDR_LAST) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));
endmodule

// File: rtl/sbist_dp.sv
module sbist_dp
  import sbist_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sb_state_e         st_i,
  input  logic              accept_i,
  input  logic              ser_in_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic              ser_out_o,
  output logic              fail_o
);
  logic pol_q, pol_d;
  logic fail_q, fail_d;
  logic cmp_en, exp_bit;
  logic [DATA_W-1:0] shift_word;

  generate
    if (DATA_W == 1) begin : g_narrow
      assign shift_word = pol_q;
    end else begin : g_wide
      assign shift_word = {pol_q, rdata_i[DATA_W-1:1]};
    end
  endgenerate

  assign wdata_o   = (st_i == ST_INIT) ? {DATA_W{~pol_q}} : shift_word;
  assign ser_out_o = rdata_i[0];
  assign cmp_en    = (st_i == ST_WR) || (st_i == ST_CHK);
  assign exp_bit   = (st_i == ST_CHK) ? pol_q : ~pol_q;

  always_comb begin
    pol_d  = accept_i ? ser_in_i : pol_q;
    fail_d = fail_q;
    if (accept_i)
      fail_d = 1'b0;
    else if (cmp_en && (ser_out_o != exp_bit))
      fail_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      if (accept_i) pol_q <= pol_d;
      if (accept_i || cmp_en) fail_q <= fail_d;
    end
  end

  assign fail_o = fail_q;

  a_r6_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !accept_i) |=> fail_q);
  a_r7_pol_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st_i != ST_IDLE) |=> $stable(pol_q));
endmodule

// File: rtl/serial_mem_bist.sv
module serial_mem_bist
  import sbist_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ser_in,
  output logic              ser_out,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              fail
);
  sb_state_e st;
  logic      accept;

  sbist_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .st_o     (st),
    .accept_o (accept),
    .addr_o   (mem_addr),
    .busy_o   (busy),
    .done_o   (done)
  );

  sbist_dp #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_i      (st),
    .accept_i  (accept),
    .ser_in_i  (ser_in),
    .rdata_i   (mem_rdata),
    .wdata_o   (mem_wdata),
    .ser_out_o (ser_out),
    .fail_o    (fail)
  );

  assign mem_we = (st == ST_INIT) || (st == ST_WR);
  assign mem_re = (st == ST_RD);

  a_r2_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  a_r5_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_we && !mem_re));
  a_r3_read_then_use: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (mem_we || busy));
endmodule

// File: tb/serial_mem_bist_tb.sv
module serial_mem_bist_tb;
  localparam int W = 8;
  localparam int A = 4;
  localparam int N = 1 << A;
  localparam int RUN_CYC = N * (2 * W + 3);

  logic clk, rst_n, start, ser_in, ser_out, mem_we, mem_re, busy, done, fail;
  logic [A-1:0] mem_addr;
  logic [W-1:0] mem_wdata, mem_rdata;

  int errors = 0;
  int checks = 0;

  logic [W-1:0] mem [N];
  logic         f_en, f_val;
  int           f_addr, f_bit;
  logic         pol;
  logic         chk_pat;
  int           wcnt [N];
  int           rcnt [N];
  int           busy_cnt, pat_err, order_err, sout_err, quiet_err, last_addr;
  logic         mid_start;

  serial_mem_bist #(.DATA_W(W), .ADDR_W(A)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ser_in(ser_in), .ser_out(ser_out),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .fail(fail)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [W-1:0] apply_fault(int a, logic [W-1:0] d);
    logic [W-1:0] r = d;
    if (f_en && a == f_addr) r[f_bit] = f_val;
    return r;
  endfunction

  function automatic logic [W-1:0] fill_pattern(int k, logic p);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (i >= W - k) ? p : ~p;
    return r;
  endfunction

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= apply_fault(int'(mem_addr), mem_wdata);
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cnt++;
      if (ser_out !== mem_rdata[0]) sout_err++;
      if (done && (mem_we || mem_re || busy)) quiet_err++;
      if (mem_we) begin
        if (chk_pat && !f_en && mem_wdata !== fill_pattern(wcnt[mem_addr], pol)) pat_err++;
        if (int'(mem_addr) < last_addr) order_err++;
        last_addr = int'(mem_addr);
        wcnt[mem_addr]++;
      end
      if (mem_re) rcnt[mem_addr]++;
    end
  end

  task automatic check(string req, logic ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(logic p, logic fe, int fa, int fb, logic fv, logic poke);
    int guard = 0;
    int bad_cnt = 0;
    int bad_mem = 0;
    pol = p; f_en = fe; f_addr = fa; f_bit = fb; f_val = fv;
    for (int i = 0; i < N; i++) begin
      mem[i] = W'($urandom); wcnt[i] = 0; rcnt[i] = 0;
    end
    busy_cnt = 0; pat_err = 0; order_err = 0; sout_err = 0; quiet_err = 0; last_addr = 0;
    @(negedge clk); start = 1'b1; ser_in = p;
    @(negedge clk); start = 1'b0;
    while (!done && guard < 4 * RUN_CYC) begin
      ser_in = 1'($urandom);
      if (poke && guard == 37) start = 1'b1;
      else start = 1'b0;
      guard++;
      @(negedge clk);
    end
    start = 1'b0;
    check("R5 watchdog", done === 1'b1, int'(done), 1);
    check("R5 busy cycles", busy_cnt == RUN_CYC, busy_cnt, RUN_CYC);
    check("R6 fail result", fail === fe, int'(fail), int'(fe));
    for (int i = 0; i < N; i++)
      if (wcnt[i] != W + 1 || rcnt[i] != W + 1) bad_cnt++;
    check("R4 ops per word", bad_cnt == 0, bad_cnt, 0);
    check("R4 ascending", order_err == 0, order_err, 0);
    check("R9 ser_out", sout_err == 0, sout_err, 0);
    if (!fe) begin
      check("R1 fill pattern", pat_err == 0, pat_err, 0);
      for (int i = 0; i < N; i++) if (mem[i] !== {W{p}}) bad_mem++;
      check("R10 final words", bad_mem == 0, bad_mem, 0);
      check("R3 no false fail", fail === 1'b0, int'(fail), 0);
    end
    repeat (5) @(negedge clk);
    check("R5 done held quiet", done === 1'b1 && quiet_err == 0, quiet_err, 0);
    check("R6 fail held", fail === fe, int'(fail), int'(fe));
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; start = 1'b0; ser_in = 1'b0; chk_pat = 1'b1;
    f_en = 1'b0; f_val = 1'b0; f_addr = 0; f_bit = 0; pol = 1'b1;
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    check("R8 reset", !busy && !done && !fail && !mem_we && !mem_re, int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // Directed: fault-free with each polarity (R1, R3, R10)
    run(1'b1, 1'b0, 0, 0, 1'b0, 1'b0);
    run(1'b0, 1'b0, 0, 0, 1'b0, 1'b0);
    // R7: start pulse and ser_in changes mid-run
    run(1'b1, 1'b0, 0, 0, 1'b0, 1'b1);
    // R6: faults at the top and bottom bits, then clearing on restart
    run(1'b1, 1'b1, 3, W - 1, 1'b0, 1'b0);
    run(1'b1, 1'b1, N - 1, 0, 1'b1, 1'b0);
    run(1'b0, 1'b1, 0, W - 1, 1'b1, 1'b0);
    run(1'b0, 1'b0, 0, 0, 1'b0, 1'b0);
    // Random stuck-at faults and polarities
    for (int t = 0; t < 10; t++)
      run(1'($urandom), 1'b1, int'($urandom % N), int'($urandom % W), 1'($urandom), 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule